// File: doc/BRIEF.md
# Configuration Word Streamer

This block takes a configuration image delivered one byte per transfer, with a marker on the final byte, and turns it into a sequence of 32-bit register writes. Bytes are gathered into words lowest byte first. Each finished word goes out through one of two write paths, chosen when a run begins: a memory-window write port, or a configuration-register port that writes the data register at a fixed address. A final short group is sent as one word whose unused upper bytes are zero.

Error checking can be turned on for a run. The block then reads the status register over the configuration-register port after every word that brings the byte total to a whole multiple of 4096. It also reads it once more after the final word. If the configuration-error bit is set in any reply, the run stops at once and reports error together with the byte total reached at that point. When checking is off, the block issues no reads at all. A start pulse clears the byte counter and the done and error flags, and it also captures the path choice and the checking choice for the run.

Top module: `cfg_word_streamer`

## Requirements
- R1: After reset, s_ready, done and error are low, byte_count is 0, and neither mem_wr_valid nor cfg_valid is asserted.
- R2: Byte k of each four-byte group (k = 0..3, in arrival order) is placed in bits 8k+7:8k of the word written.
- R3: A final group of 1 to 3 bytes is written as one word with the unused upper bytes zero. A stream whose length is a multiple of 4 produces no extra word.
- R4: With path_mem = 1 at start, words are written only on the memory port. With path_mem = 0, words are written only on the config port, with cfg_write = 1 and cfg_addr = 0x228.
- R5: Only one write or status read is outstanding at a time. s_ready is low while a request is pending or awaiting its reply. A request is held stable until it is accepted.
- R6: With chk_en = 1 at start, a status read (cfg_write = 0, cfg_addr = 0x21C) is issued after each word write that brings the byte total to a multiple of 4096, and before any further byte is accepted.
- R7: With chk_en = 1, one more status read follows the last word write. This extra read is issued even when the last word also ends on a 4096 boundary, giving two reads in a row.
- R8: If bit 19 of any status reply is set, the run stops: error and done go high, byte_count holds the total at that check, and no further bytes or requests follow until the next start.
- R9: With chk_en = 0 at start, no status read is issued during the run.
- R10: A start pulse clears byte_count, done and error. byte_count then counts every byte accepted.
- R11: A run that ends without error raises done, with error low and byte_count equal to the stream length, once its last write and checks have completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a run and clears counter and flags |
| chk_en | input | 1 | Status checking enable, captured at start |
| path_mem | input | 1 | 1 selects the memory write port, 0 the config port; captured at start |
| s_valid | input | 1 | Input byte valid |
| s_data | input | 8 | Input byte |
| s_last | input | 1 | Marks the final byte of the image |
| s_ready | output | 1 | Block accepts a byte this cycle |
| mem_wr_valid | output | 1 | Memory-window write request (offset 0) |
| mem_wr_data | output | 32 | Memory-window write data |
| mem_wr_ready | input | 1 | Memory-window write accepted |
| cfg_valid | output | 1 | Config-register request |
| cfg_write | output | 1 | 1 = write, 0 = read |
| cfg_addr | output | 12 | Config-register address |
| cfg_wdata | output | 32 | Config-register write data |
| cfg_ready | input | 1 | Config-register request accepted |
| cfg_rvalid | input | 1 | Read reply valid |
| cfg_rdata | input | 32 | Read reply data |
| byte_count | output | 32 | Bytes accepted in the current run |
| done | output | 1 | Run finished |
| error | output | 1 | Run aborted on a configuration error |

## Verification
Two checks fall due after the same word when the image ends on a 4096-byte boundary: the periodic check and the final check. A 4096-byte stream with checking on provokes this. The scoreboard expects two separate status reads back to back after the last data write, not one merged read. The same coincidence is pushed further by placing the error bit in the boundary reply, the final reply, or a boundary reply in the middle of the image, each with the ready inputs stalling at random. The stop point is then judged by the byte total and by the absence of any later request.

// File: rtl/cfgs_pkg.sv
`timescale 1ns/1ps
package cfgs_pkg;
    localparam int WORD_W = 32;
    localparam int CNT_W  = 32;
    localparam int LANES  = WORD_W / 8;
    localparam int LANE_W = $clog2(LANES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_WR,
        ST_RDQ,
        ST_RDW
    } stream_st_t;

    typedef struct packed {
        logic need_span;
        logic need_fin;
    } chk_need_t;

    function automatic logic on_span(input logic [CNT_W-1:0] cnt, input int span_log2);
        logic [CNT_W-1:0] m;
        m = (CNT_W'(1) << span_log2) - CNT_W'(1);
        return (cnt & m) == '0;
    endfunction
endpackage

// File: rtl/cfgs_packer.sv
`timescale 1ns/1ps
module cfgs_packer
    import cfgs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic              last,
    input  logic [7:0]        din,
    output logic [LANE_W-1:0] lane,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] nxt;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            if (lane == LANE_W'(i))
                nxt[8*i +: 8] = din;
            else if (lane == '0)
                nxt[8*i +: 8] = 8'h00;
            else
                nxt[8*i +: 8] = word[8*i +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lane <= '0;
            word <= '0;
        end else if (push) begin
            word <= nxt;
            lane <= (last || lane == LANE_W'(LANES-1)) ? '0 : lane + LANE_W'(1);
        end
    end

    p_lane_restart_r3: assert property (@(posedge clk) disable iff (rst)
        (push && last && !clr) |=> lane == '0);
endmodule

// File: rtl/cfgs_check_sched.sv
`timescale 1ns/1ps
module cfgs_check_sched
    import cfgs_pkg::*;
#(
    parameter int SPAN_LOG2 = 12
) (
    input  logic             chk_on,
    input  logic             word_last,
    input  logic [CNT_W-1:0] total,
    output chk_need_t        need
);
    always_comb begin
        need.need_span = chk_on && on_span(total, SPAN_LOG2);
        need.need_fin  = chk_on && word_last;
    end
endmodule

// File: rtl/cfgs_port_mux.sv
`timescale 1ns/1ps
module cfgs_port_mux
    import cfgs_pkg::*;
#(
    parameter int                CFG_AW      = 12,
    parameter logic [CFG_AW-1:0] DATA_ADDR   = 12'h228,
    parameter logic [CFG_AW-1:0] STATUS_ADDR = 12'h21C
) (
    input  logic              issue_wr,
    input  logic              issue_rd,
    input  logic              use_mem,
    input  logic [WORD_W-1:0] wdata,
    input  logic              mem_wr_ready,
    input  logic              cfg_ready,
    output logic              mem_wr_valid,
    output logic [WORD_W-1:0] mem_wr_data,
    output logic              cfg_valid,
    output logic              cfg_write,
    output logic [CFG_AW-1:0] cfg_addr,
    output logic [WORD_W-1:0] cfg_wdata,
    output logic              accepted
);
    always_comb begin
        mem_wr_valid = issue_wr && use_mem;
        mem_wr_data  = wdata;
        cfg_valid    = (issue_wr && !use_mem) || issue_rd;
        cfg_write    = issue_wr && !use_mem;
        cfg_addr     = issue_rd ? STATUS_ADDR : DATA_ADDR;
        cfg_wdata    = issue_rd ? '0 : wdata;
        accepted     = (mem_wr_valid && mem_wr_ready) || (cfg_valid && cfg_ready);
    end
endmodule

// File: rtl/cfg_word_streamer.sv
`timescale 1ns/1ps
module cfg_word_streamer
    import cfgs_pkg::*;
#(
    parameter int                CFG_AW      = 12,
    parameter logic [CFG_AW-1:0] DATA_ADDR   = 12'h228,
    parameter logic [CFG_AW-1:0] STATUS_ADDR = 12'h21C,
    parameter int                ERR_BIT     = 19,
    parameter int                SPAN_LOG2   = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              chk_en,
    input  logic              path_mem,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              mem_wr_valid,
    output logic [31:0]       mem_wr_data,
    input  logic              mem_wr_ready,
    output logic              cfg_valid,
    output logic              cfg_write,
    output logic [CFG_AW-1:0] cfg_addr,
    output logic [31:0]       cfg_wdata,
    input  logic              cfg_ready,
    input  logic              cfg_rvalid,
    input  logic [31:0]       cfg_rdata,
    output logic [31:0]       byte_count,
    output logic              done,
    output logic              error
);
    stream_st_t        st;
    logic              chk_q, path_q, last_q, fin_pend;
    logic [CNT_W-1:0]  cnt;
    logic [LANE_W-1:0] lane;
    logic [WORD_W-1:0] word;
    logic              push, word_end, accepted;
    chk_need_t         need;

    assign push     = (st == ST_RUN) && s_valid;
    assign word_end = push && (s_last || lane == LANE_W'(LANES-1));
    assign s_ready  = (st == ST_RUN);

    cfgs_packer u_pack (
        .clk(clk), .rst(rst), .clr(start), .push(push), .last(s_last),
        .din(s_data), .lane(lane), .word(word)
    );

    cfgs_check_sched #(.SPAN_LOG2(SPAN_LOG2)) u_sched (
        .chk_on(chk_q), .word_last(last_q), .total(cnt), .need(need)
    );

    cfgs_port_mux #(.CFG_AW(CFG_AW), .DATA_ADDR(DATA_ADDR), .STATUS_ADDR(STATUS_ADDR)) u_mux (
        .issue_wr(st == ST_WR), .issue_rd(st == ST_RDQ), .use_mem(path_q),
        .wdata(word), .mem_wr_ready(mem_wr_ready), .cfg_ready(cfg_ready),
        .mem_wr_valid(mem_wr_valid), .mem_wr_data(mem_wr_data),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .accepted(accepted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            chk_q    <= 1'b0;
            path_q   <= 1'b0;
            last_q   <= 1'b0;
            fin_pend <= 1'b0;
            cnt      <= '0;
            done     <= 1'b0;
            error    <= 1'b0;
        end else if (start) begin
            st       <= ST_RUN;
            chk_q    <= chk_en;
            path_q   <= path_mem;
            last_q   <= 1'b0;
            fin_pend <= 1'b0;
            cnt      <= '0;
            done     <= 1'b0;
            error    <= 1'b0;
        end else begin
            case (st)
                ST_RUN: if (push) begin
                    cnt <= cnt + CNT_W'(1);
                    if (word_end) begin
                        st     <= ST_WR;
                        last_q <= s_last;
                    end
                end
                ST_WR: if (accepted) begin
                    if (need.need_span) begin
                        st       <= ST_RDQ;
                        fin_pend <= need.need_fin;
                    end else if (need.need_fin) begin
                        st       <= ST_RDQ;
                        fin_pend <= 1'b0;
                    end else if (last_q) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end else begin
                        st <= ST_RUN;
                    end
                end
                ST_RDQ: if (accepted) st <= ST_RDW;
                ST_RDW: if (cfg_rvalid) begin
                    if (cfg_rdata[ERR_BIT]) begin
                        st    <= ST_IDLE;
                        error <= 1'b1;
                        done  <= 1'b1;
                    end else if (fin_pend) begin
                        st       <= ST_RDQ;
                        fin_pend <= 1'b0;
                    end else if (last_q) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end else begin
                        st <= ST_RUN;
                    end
                end
                default: ;
            endcase
        end
    end

    assign byte_count = cnt;

    p_one_port_r4: assert property (@(posedge clk) disable iff (rst)
        !(mem_wr_valid && cfg_valid));
    p_busy_no_ready_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid || cfg_valid) |-> !s_ready);
    p_hold_write_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ready && !start) |=> (mem_wr_valid && $stable(mem_wr_data)));
    p_no_read_unchecked_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && !cfg_write) |-> chk_q);
    p_error_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (error && !start) |=> (error && done && $stable(byte_count)));
    p_count_step_r10: assert property (@(posedge clk) disable iff (rst)
        !start |=> (byte_count == $past(byte_count) || byte_count == $past(byte_count) + 32'd1));
    p_done_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> (!s_ready && !mem_wr_valid && !cfg_valid));
endmodule

// File: tb/sim_cfg_word_streamer.sv
`timescale 1ns/1ps
module sim_cfg_word_streamer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, chk_en = 1'b0, path_mem = 1'b0;
    logic        s_valid = 1'b0, s_last = 1'b0;
    logic [7:0]  s_data = 8'h00;
    logic        s_ready;
    logic        mem_wr_valid, mem_wr_ready;
    logic [31:0] mem_wr_data;
    logic        cfg_valid, cfg_write, cfg_ready;
    logic [11:0] cfg_addr;
    logic [31:0] cfg_wdata;
    logic        cfg_rvalid;
    logic [31:0] cfg_rdata;
    logic [31:0] byte_count;
    logic        done, error;

    always #2.5 clk = ~clk;

    cfg_word_streamer u0 (
        .clk(clk), .rst(rst), .start(start), .chk_en(chk_en), .path_mem(path_mem),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .mem_wr_valid(mem_wr_valid), .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_ready(cfg_ready), .cfg_rvalid(cfg_rvalid),
        .cfg_rdata(cfg_rdata), .byte_count(byte_count), .done(done), .error(error)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // ready generation and status responder
    logic [7:0] lf = 8'h01;
    bit         stall = 1'b0;
    int         err_rd = 0;
    int         rd_num = 0;
    logic       rd_pend = 1'b0;
    logic [31:0] rd_data_q = '0;
    initial begin mem_wr_ready = 1'b1; cfg_ready = 1'b1; cfg_rvalid = 1'b0; cfg_rdata = '0; end

    always @(posedge clk) begin
        lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        mem_wr_ready <= stall ? lf[0] : 1'b1;
        cfg_ready    <= stall ? lf[2] : 1'b1;
        cfg_rvalid   <= rd_pend;
        cfg_rdata    <= rd_data_q;
        rd_pend      <= cfg_valid && cfg_ready && !cfg_write;
        if (start) rd_num <= 0;
        else if (cfg_valid && cfg_ready && !cfg_write) begin
            rd_num    <= rd_num + 1;
            rd_data_q <= ((rd_num + 1) == err_rd) ? 32'h0008_0004 : 32'h0004_0004;
        end
    end

    // scoreboard: kind 0 = memory write, 1 = config write, 2 = status read
    typedef struct {
        int          kind;
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t q[$];

    always @(negedge clk) begin
        if (!rst) begin
            if ((mem_wr_valid || cfg_valid) && s_ready)
                chk(1'b0, "R5", "s_ready high with request pending", 1, 0);
            if ((mem_wr_valid && mem_wr_ready) || (cfg_valid && cfg_ready)) begin
                int kind;
                kind = mem_wr_valid ? 0 : (cfg_write ? 1 : 2);
                if (q.size() == 0) begin
                    chk(1'b0, (kind == 2) ? "R9" : "R8", "unexpected request kind", kind, -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(kind == e.kind, (kind == 2 || e.kind == 2) ? e.tag : "R4",
                        "request kind", kind, e.kind);
                    if (kind == 1)
                        chk(cfg_addr == 12'h228, "R4", "data register address", cfg_addr, 12'h228);
                    if (kind == 2)
                        chk(cfg_addr == 12'h21C, e.tag, "status register address", cfg_addr, 12'h21C);
                    if (kind != 2 && e.kind != 2)
                        chk((kind == 0 ? mem_wr_data : cfg_wdata) == e.data, e.tag, "word data",
                            kind == 0 ? mem_wr_data : cfg_wdata, e.data);
                end
            end
        end
    end

    function automatic logic [7:0] bval(input int i, input int seed);
        return 8'((i * 37 + seed) ^ (i >> 8)) | 8'h01;
    endfunction

    task automatic run_stream(input int n, input bit pm, input bit ck,
                              input int erd, input bit stl, input int seed);
        int c = 0, rd = 0, i = 0;
        bit stop = 0;
        int exp_cnt;
        exp_cnt = n;
        for (int w = 0; w * 4 < n && !stop; w++) begin
            exp_t e;
            int len;
            bit lastw;
            len = (n - 4 * w) < 4 ? (n - 4 * w) : 4;
            e.kind = pm ? 0 : 1;
            e.data = '0;
            for (int b = 0; b < len; b++) e.data[8*b +: 8] = bval(4 * w + b, seed);
            e.tag = (len < 4) ? "R3" : "R2";
            q.push_back(e);
            c += len;
            lastw = (c == n);
            if (ck && (c % 4096) == 0) begin
                rd++;
                e.kind = 2; e.data = '0; e.tag = "R6";
                q.push_back(e);
                if (rd == erd) begin stop = 1; exp_cnt = c; end
            end
            if (!stop && ck && lastw) begin
                rd++;
                e.kind = 2; e.data = '0; e.tag = "R7";
                q.push_back(e);
                if (rd == erd) begin stop = 1; exp_cnt = c; end
            end
        end
        @(negedge clk);
        err_rd = erd; stall = stl;
        start = 1'b1; chk_en = ck; path_mem = pm;
        @(negedge clk);
        start = 1'b0;
        chk(byte_count == 0 && !done && !error, "R10", "cleared after start",
            {byte_count, done, error}, 0);
        while (i < n && !done) begin
            s_valid = 1'b1;
            s_data  = bval(i, seed);
            s_last  = (i == n - 1);
            if (s_ready) i++;
            @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0;
        while (!done) @(negedge clk);
        repeat (8) @(negedge clk);
        chk(q.size() == 0, stop ? "R8" : (ck ? "R7" : "R11"), "outstanding expected requests", q.size(), 0);
        q.delete();
        chk(byte_count == 32'(exp_cnt), stop ? "R8" : "R10", "byte_count", byte_count, exp_cnt);
        chk(error == stop, stop ? "R8" : "R11", "error flag", error, stop);
        chk(done && !s_ready, stop ? "R8" : "R11", "done and idle", {done, s_ready}, 2'b10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!s_ready && !done && !error && byte_count == 0 && !mem_wr_valid && !cfg_valid,
            "R1", "reset state", {s_ready, done, error, mem_wr_valid, cfg_valid}, 0);
        run_stream(8,    1, 0, 0, 0, 3);   // R2 R4 memory path, R9 no checks
        run_stream(7,    0, 1, 0, 1, 11);  // R3 partial of 3, R7 final read, R4 config path
        run_stream(5,    1, 1, 0, 0, 29);  // R3 partial of 1
        run_stream(12,   0, 0, 0, 1, 41);  // R3 exact multiple, no extra word
        run_stream(4096, 0, 1, 0, 0, 5);   // R6 and R7 after the same word
        run_stream(8200, 1, 1, 2, 1, 7);   // R8 error on second boundary read
        run_stream(4096, 1, 1, 2, 1, 17);  // R8 error on final read at a boundary
        run_stream(4100, 0, 1, 1, 0, 13);  // R8 error on first boundary read
        run_stream(4100, 1, 0, 0, 0, 19);  // R9 checking off over a boundary
        run_stream(9,    0, 1, 1, 1, 23);  // R8 error on final read, R10 restart clears
        run_stream(4,    1, 1, 0, 0, 31);  // R11 single word clean finish
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule